// File: doc/BRIEF.md
# HDLC Frame Receiver with Dual Address Filter

This block takes a serial HDLC bit stream that upstream logic has already cut out of an E1 frame. It arrives as one data bit plus a qualifier that marks each cycle carrying a valid bit. The receiver finds the opening and closing flags and drops stuffed zeros. It can verify the 16-bit frame check sequence, and it can keep only those frames whose first byte equals one of two programmable addresses. Each payload byte of an accepted frame goes into a receive FIFO. The two FCS bytes are never stored.

The host side is a small register port with a 2-bit address, a write strobe and a read strobe. Read data is combinational. The host reads the status register first, which tells it whether a byte is waiting and whether that byte closes a packet. The host then reads the data register, and that read pops the byte. An interrupt output reports when the FIFO fill exceeds a programmable threshold.

Register writes:
- Address 0: b0 enables the receiver, b1 turns on address matching, b2 turns on the FCS check.
- Address 1: b7 enables the interrupt, b6..b0 hold the threshold.
- Address 2: primary match address.
- Address 3: secondary match address.

Register reads:
- Address 0: status.
- Address 1: FIFO head byte; this read pops it.
- Addresses 2 and 3: the match addresses.

Top module: `hdlc_addr_rx`

## Requirements
- R1: After reset, the status read (address 0) returns 0x00, irq is low, and the primary address reads back 0x00.
- R2: While the enable bit (write address 0, b0) is 0, no byte enters the FIFO, whatever arrives on the line.
- R3: Between two 0x7E flags, every payload byte of an accepted frame is delivered in order, and the last two bytes (the FCS) are stripped. Status b0 is set while a byte is waiting. Status b1 is set when the head byte ends its packet. Reading address 1 returns the head byte and pops it.
- R4: A zero that follows five consecutive ones is removed, so payload bytes made of runs of ones are delivered unchanged.
- R5: With the check on (write address 0, b2), status b2 is set alongside the last byte when the reflected CRC-CCITT residue (preset 0xFFFF) is not 0xF0B8. With the check off, status b2 stays 0.
- R6: With matching on (write address 0, b1), a frame is stored only when its first byte equals the primary address (address 2) or the secondary address (address 3).
- R7: Seven consecutive ones abort the frame. Nothing is stored if no byte of it has yet been written. Otherwise the last byte written carries both end-of-packet and bad. The receiver then waits for a new flag.
- R8: irq is high exactly when the interrupt enable (write address 1, b7) is 1 and the FIFO holds more bytes than the 7-bit threshold (write address 1, b6..b0).
- R9: A byte that arrives while the FIFO already holds FIFO_DEPTH entries is dropped and sets status b3. Status b3 stays set until a status read clears it. A new overflow in the same cycle as that status read wins, and b3 stays set.
- R10: Cycles with rxEn low are ignored completely.
- R11: A frame with fewer than three bytes between its flags stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Serial line bit |
| rxEn | input | 1 | Marks rxBit as valid in this cycle |
| hostAddr | input | 2 | Register address |
| hostWr | input | 1 | Register write strobe |
| hostWrData | input | 8 | Register write data |
| hostRd | input | 1 | Register read strobe (pops at address 1) |
| hostRdData | output | 8 | Combinational register read data |
| irq | output | 1 | FIFO fill above threshold |

## Verification
The receiver can push a byte into the FIFO in the same cycle as a host pop. The bench provokes this by leaving one frame stored and then draining it while a second long frame streams in on the line. It judges the result by the exact order and end-of-packet tags of both frames, and by the absence of any overflow. An overflow set can also coincide with the status read that clears the flag. A bound property requires the flag to survive in that case. The bench also forces a real overflow and checks that the flag is set and is cleared on the second read.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam int          BYTE_W     = 8;

  typedef struct packed {
    logic              enable;
    logic              addrMatch;
    logic              crcCheck;
    logic [BYTE_W-1:0] addrPri;
    logic [BYTE_W-1:0] addrSec;
  } rxCfg_t;

  typedef struct packed {
    logic              wrEn;
    logic              wrEop;
    logic              wrBad;
    logic [BYTE_W-1:0] wrData;
  } rxStrobe_t;

  // byte-wide update of the reflected CCITT checksum
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < BYTE_W; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int HOLD_BYTES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxBit,
  input  logic      rxEn,
  input  rxCfg_t    cfg,
  output rxStrobe_t strb
);
  localparam int HCNT_W = $clog2(HOLD_BYTES + 1);

  logic              hunting;
  logic [2:0]        ones;
  logic [BYTE_W-1:0] shiftReg;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] held [HOLD_BYTES+1];
  logic [HCNT_W-1:0] heldCnt;
  logic              firstDone, accept;
  logic [15:0]       crc;

  logic isAbort, isFlag, isData, closeFrame, frameBad, addrOk;
  logic [BYTE_W-1:0] nextShift;

  always_comb begin
    isAbort    = rxBit && (ones >= 3'd6);
    isFlag     = !rxBit && (ones == 3'd6);
    isData     = !hunting && (rxBit ? (ones < 3'd5) : (ones != 3'd5 && ones != 3'd6));
    closeFrame = !hunting && (isAbort || isFlag);
    frameBad   = isAbort || (bitCnt != 3'd6) || (cfg.crcCheck && crc != CRC_GOOD);
    nextShift  = {rxBit, shiftReg[BYTE_W-1:1]};
    addrOk     = !cfg.addrMatch || nextShift == cfg.addrPri || nextShift == cfg.addrSec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hunting   <= 1'b1;
      ones      <= '0;
      shiftReg  <= '0;
      bitCnt    <= '0;
      heldCnt   <= '0;
      firstDone <= 1'b0;
      accept    <= 1'b0;
      crc       <= CRC_PRESET;
      strb      <= '0;
      for (int i = 0; i <= HOLD_BYTES; i++) held[i] <= '0;
    end else begin
      strb <= '0;
      if (!cfg.enable) begin
        hunting <= 1'b1;
        ones    <= '0;
      end else if (rxEn) begin
        if (rxBit) ones <= (ones == 3'd7) ? 3'd7 : ones + 3'd1;
        else       ones <= '0;
        if (closeFrame && heldCnt == HCNT_W'(HOLD_BYTES) && accept) begin
          strb.wrEn   <= 1'b1;
          strb.wrEop  <= 1'b1;
          strb.wrBad  <= frameBad;
          strb.wrData <= held[0];
        end
        if (isAbort) begin
          hunting <= 1'b1;
        end else if (isFlag) begin
          hunting   <= 1'b0;
          bitCnt    <= '0;
          heldCnt   <= '0;
          firstDone <= 1'b0;
          accept    <= 1'b0;
          crc       <= CRC_PRESET;
        end else if (isData) begin
          shiftReg <= nextShift;
          bitCnt   <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            crc <= crcStep(crc, nextShift);
            if (!firstDone) begin
              firstDone <= 1'b1;
              accept    <= addrOk;
            end
            if (heldCnt == HCNT_W'(HOLD_BYTES)) begin
              strb.wrEn   <= accept;
              strb.wrData <= held[0];
              for (int i = 0; i < HOLD_BYTES - 1; i++) held[i] <= held[i+1];
              held[HOLD_BYTES-1] <= nextShift;
            end else begin
              held[heldCnt] <= nextShift;
              heldCnt       <= heldCnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_dpath.sv
module hdlc_rx_dpath
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int TH_W  = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   hostAddr,
  input  logic                         hostWr,
  input  logic [BYTE_W-1:0]            hostWrData,
  input  logic                         hostRd,
  output logic [BYTE_W-1:0]            hostRdData,
  input  rxStrobe_t                    strb,
  output rxCfg_t                       cfg,
  output logic                         irq,
  output logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  output logic                         ovfFlag
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = BYTE_W + 2;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             intEn;
  logic [TH_W-1:0]  thresh;
  logic             full, push, pop, statusRd;
  logic [ENT_W-1:0] head;
  logic [BYTE_W-1:0] statusByte;

  always_comb begin
    full       = (fifoCount == CNT_W'(DEPTH));
    push       = strb.wrEn && !full;
    pop        = hostRd && hostAddr == 2'd1 && fifoCount != '0;
    statusRd   = hostRd && hostAddr == 2'd0;
    head       = mem[rdPtr];
    statusByte = {4'b0, ovfFlag, head[ENT_W-1] && fifoCount != '0,
                  head[ENT_W-2] && fifoCount != '0, fifoCount != '0};
    irq        = intEn && (32'(fifoCount) > 32'(thresh));
    case (hostAddr)
      2'd0:    hostRdData = statusByte;
      2'd1:    hostRdData = (fifoCount != '0) ? head[BYTE_W-1:0] : '0;
      2'd2:    hostRdData = cfg.addrPri;
      default: hostRdData = cfg.addrSec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {strb.wrBad, strb.wrEop, strb.wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg       <= '0;
      intEn     <= 1'b0;
      thresh    <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      ovfFlag   <= 1'b0;
    end else begin
      if (hostWr) begin
        case (hostAddr)
          2'd0: begin
            cfg.enable    <= hostWrData[0];
            cfg.addrMatch <= hostWrData[1];
            cfg.crcCheck  <= hostWrData[2];
          end
          2'd1: begin
            intEn  <= hostWrData[7];
            thresh <= hostWrData[TH_W-1:0];
          end
          2'd2:    cfg.addrPri <= hostWrData;
          default: cfg.addrSec <= hostWrData;
        endcase
      end
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
      if (strb.wrEn && full) ovfFlag <= 1'b1;
      else if (statusRd)     ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       rxEn,
  input  logic [1:0] hostAddr,
  input  logic       hostWr,
  input  logic [7:0] hostWrData,
  input  logic       hostRd,
  output logic [7:0] hostRdData,
  output logic       irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  rxCfg_t           cfg;
  rxStrobe_t        strb;
  logic [CNT_W-1:0] fifoCount;
  logic             ovfFlag;

  hdlc_rx_ctrl #(.HOLD_BYTES(3)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxEn(rxEn), .cfg(cfg), .strb(strb)
  );

  hdlc_rx_dpath #(.DEPTH(FIFO_DEPTH), .TH_W(7)) dpath_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRd(hostRd), .hostRdData(hostRdData),
    .strb(strb), .cfg(cfg), .irq(irq), .fifoCount(fifoCount), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/hdlc_rx_checker.sv
module hdlc_rx_checker
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxEn,
  input logic             hostRd,
  input logic [1:0]       hostAddr,
  input rxCfg_t           cfg,
  input rxStrobe_t        strb,
  input logic [CNT_W-1:0] fifoCount,
  input logic             ovfFlag,
  input logic             irq
);
  p_dis_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> !strb.wrEn);

  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !strb.wrEn);

  p_bad_on_eop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrBad) |-> strb.wrEop);

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && 32'(fifoCount) == DEPTH) |=> ovfFlag);

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(hostRd && hostAddr == 2'd0)) |=> ovfFlag);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    32'(fifoCount) <= DEPTH);

  p_irq_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> fifoCount != '0);

  p_pop_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 2'd1 && fifoCount != '0 && !strb.wrEn)
      |=> fifoCount == $past(fifoCount) - 1'b1);
endmodule

bind hdlc_addr_rx hdlc_rx_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .rxEn(rxEn), .hostRd(hostRd), .hostAddr(hostAddr),
  .cfg(cfg), .strb(strb), .fifoCount(fifoCount), .ovfFlag(ovfFlag), .irq(irq)
);

// File: tb/hdlc_addr_rx_tb_top.sv
module hdlc_addr_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;

  logic clk = 1'b0, rstN = 1'b0, rxBit = 1'b0, rxEn = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWrData = 8'd0;
  logic [7:0] hostRdData;
  logic irq;

  int checks = 0, errors = 0, txOnes = 0;
  bit done = 1'b0, gaps = 1'b1, cfgMatch = 1'b0, cfgCrc = 1'b0;
  logic [7:0] cfgPri = 8'h13, cfgSec = 8'hFF;
  logic [9:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_addr_rx #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxEn(rxEn), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostWrData(hostWrData), .hostRd(hostRd),
    .hostRdData(hostRdData), .irq(irq)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  // all tasks start and end at a falling edge
  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdData;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic sendRaw(input logic b);
    if (gaps && $urandom_range(3) == 0) begin
      rxEn = 1'b0; rxBit = 1'($urandom);
      @(negedge clk);
    end
    rxBit = b; rxEn = 1'b1;
    @(negedge clk);
    rxEn = 1'b0; rxBit = 1'($urandom);
  endtask

  task automatic sendByte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      sendRaw(d[i]);
      if (d[i]) begin
        txOnes++;
        if (txOnes == 5) begin sendRaw(1'b0); txOnes = 0; end
      end else txOnes = 0;
    end
  endtask

  task automatic sendFlag();
    for (int i = 0; i < 8; i++) sendRaw(8'h7E >> i);
    txOnes = 0;
  endtask

  task automatic sendAbort();
    for (int i = 0; i < 7; i++) sendRaw(1'b1);
    txOnes = 0;
  endtask

  task automatic sendFrame(input logic [7:0] q[$], input bit goodFcs);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    sendFlag();
    foreach (q[i]) begin sendByte(q[i]); c = benchCrc(c, q[i]); end
    fcs = ~c;
    if (!goodFcs) fcs[0] = ~fcs[0];
    sendByte(fcs[7:0]);
    sendByte(fcs[15:8]);
    sendFlag();
    repeat (4) @(negedge clk);
  endtask

  function automatic void expectFrame(input logic [7:0] q[$], input bit goodFcs);
    bit bad = cfgCrc && !goodFcs;
    if (q.size() == 0) return;
    if (cfgMatch && q[0] != cfgPri && q[0] != cfgSec) return;
    foreach (q[i]) begin
      bit last = (i == q.size() - 1);
      expQ.push_back({bad && last, last, q[i]});
    end
  endfunction

  task automatic drainOne(input string req);
    logic [7:0] s, d;
    logic [9:0] e = expQ.pop_front();
    hostRead(2'd0, s);
    check({req, " status"}, s[2:0] == {e[9], e[8], 1'b1}, s[2:0], {e[9], e[8], 1'b1});
    hostRead(2'd1, d);
    check({req, " data"}, d == e[7:0], d, e[7:0]);
  endtask

  task automatic drainAll(input string req);
    logic [7:0] s;
    while (expQ.size() != 0) drainOne(req);
    hostRead(2'd0, s);
    check({req, " empty"}, s[0] == 1'b0, s[0], 0);
  endtask

  task automatic setCtrl(input bit en, input bit match, input bit crcOn);
    cfgMatch = match; cfgCrc = crcOn;
    hostWrite(2'd0, {5'b0, crcOn, match, en});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    logic [7:0] q[$];
    logic [7:0] qa[$];
    logic [7:0] qb[$];
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    hostRead(2'd0, s); check("R1 status", s == 8'h00, s, 0);
    check("R1 irq", irq == 1'b0, irq, 0);
    hostRead(2'd2, d); check("R1 primary", d == 8'h00, d, 0);

    hostWrite(2'd2, cfgPri);
    hostWrite(2'd3, cfgSec);
    setCtrl(1, 1, 1);

    // R3 basic delivery
    q = '{8'h13, 8'h01, 8'h02, 8'h03};
    expectFrame(q, 1); sendFrame(q, 1); drainAll("R3");

    // R4 runs of ones needing stuffing
    q = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'h1F};
    expectFrame(q, 1); sendFrame(q, 1); drainAll("R4");

    // R5 bad checksum tagged
    q = '{8'h13, 8'h55, 8'hAA};
    expectFrame(q, 0); sendFrame(q, 0); drainAll("R5 check on");

    // R6 unmatched address dropped, matched one kept
    q = '{8'h12, 8'h44};
    expectFrame(q, 1); sendFrame(q, 1);
    q = '{8'hFF, 8'h45};
    expectFrame(q, 1); sendFrame(q, 1); drainAll("R6");

    // R11 frame with only two bytes between flags
    q = {};
    sendFrame(q, 1); drainAll("R11");

    // R7 abort: short frame stores nothing, long one ends bad
    sendFlag(); sendByte(8'h13); sendAbort(); sendFlag();
    sendByte(8'h13); sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3); sendByte(8'hA4);
    sendAbort(); repeat (4) @(negedge clk);
    expQ.push_back({2'b00, 8'h13}); expQ.push_back({2'b00, 8'hA1}); expQ.push_back({2'b11, 8'hA2});
    drainAll("R7");
    q = '{8'h13, 8'h77};
    expectFrame(q, 1); sendFrame(q, 1); drainAll("R7 recovery");

    // R3 host pop concurrent with receiver push
    qa = {}; qb = {};
    qa.push_back(8'h13); qb.push_back(8'h13);
    for (int i = 0; i < 19; i++) begin qa.push_back(8'($urandom)); qb.push_back(8'($urandom)); end
    expectFrame(qa, 1); sendFrame(qa, 1);
    expectFrame(qb, 1);
    fork
      sendFrame(qb, 1);
      for (int i = 0; i < 20; i++) drainOne("R3 overlap");
    join
    drainAll("R3 overlap tail");

    // R8 threshold interrupt
    hostWrite(2'd1, 8'h8F);
    q = '{8'h13};
    for (int i = 0; i < 14; i++) q.push_back(8'($urandom));
    expectFrame(q, 1); sendFrame(q, 1);
    check("R8 at threshold", irq == 1'b0, irq, 0);
    q = '{8'h13};
    expectFrame(q, 1); sendFrame(q, 1);
    check("R8 above threshold", irq == 1'b1, irq, 1);
    hostWrite(2'd1, 8'h0F);
    check("R8 disabled", irq == 1'b0, irq, 0);
    hostWrite(2'd1, 8'h8F);
    drainOne("R8");
    check("R8 after pop", irq == 1'b0, irq, 0);
    drainAll("R8");
    hostWrite(2'd1, 8'h00);

    // R2 receiver disabled
    setCtrl(0, 1, 1);
    q = '{8'h13, 8'h21, 8'h22};
    sendFrame(q, 1); drainAll("R2");
    setCtrl(1, 1, 1);

    // R5 check off
    setCtrl(1, 1, 0);
    q = '{8'h13, 8'h99};
    expectFrame(q, 0); sendFrame(q, 0); drainAll("R5 check off");

    // R9 overflow
    setCtrl(1, 0, 1);
    q = {};
    for (int i = 0; i < DEPTH + 12; i++) q.push_back(8'(i * 7 + 3));
    sendFrame(q, 1);
    hostRead(2'd0, s); check("R9 sticky set", s[3] == 1'b1, s[3], 1);
    hostRead(2'd0, s); check("R9 cleared by read", s[3] == 1'b0, s[3], 0);
    for (int i = 0; i < DEPTH; i++) expQ.push_back({2'b00, q[i]});
    drainAll("R9");

    // R6 / R10 random frames with idle gaps
    setCtrl(1, 1, 1);
    for (int f = 0; f < 30; f++) begin
      int len = $urandom_range(10);
      bit good = ($urandom_range(3) != 0);
      int pick = $urandom_range(2);
      q = {};
      for (int i = 0; i < len; i++) q.push_back(8'($urandom));
      if (len > 0) q[0] = (pick == 0) ? cfgPri : (pick == 1) ? cfgSec : 8'($urandom);
      expectFrame(q, good); sendFrame(q, good); drainAll("R10 R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule